// File: doc/BRIEF.md
# Configurable Logic-Cell Storage Element

This block is one storage bit of a programmable logic block. Static configuration inputs turn it into an edge-triggered D register, an edge-triggered T register or a level-sensitive transparent latch. A sum-term input and one extra term are combined ahead of the storage element. In plain use they are combined by an XOR. In the emulation settings they act as the two inputs of a J-K or S-R flip-flop. The stored value is fed back to form the next state.

The cell's clock, or its enable in latch mode, is taken from one of the shared block clocks. It can instead come from the cell's own clock input. The chosen signal can be used true or inverted. Asynchronous clear and set inputs override the cell at any time. A power-up initialisation input loads a configurable start value.

All configuration pins are expected to change only while the power-up input is held. The pins are plain levels: nothing at the edge of the block is buffered or handshaked.

Top module: `mcell_reg`

## Requirements
- R1: With `cfg_mode`=0 (D register) and `cfg_emu`=0, `q` takes the data value on each active edge of the selected clock and holds it at both clock levels and on the other edge.
- R2: With `cfg_mode`=1 (T register) and `cfg_emu`=0, the data value acts as T on the active edge. When T=1, `q` inverts; when T=0, `q` holds.
- R3: With `cfg_mode`=2 (latch), `q` follows the data value while the selected clock is at its active level and holds it otherwise. `cfg_emu` has no effect in this mode.
- R4: `cfg_clk_inv`=0 makes the rising edge, or the high level, active. `cfg_clk_inv`=1 makes the falling edge, or the low level, active.
- R5: In plain use (`cfg_emu`=0) the data value is `sum_term ^ xor_term ^ cfg_sum_inv`. In every setting, `cfg_sum_inv`=1 inverts `sum_term` before it is used.
- R6: With `cfg_emu`=1 (J-K), J is the possibly inverted `sum_term` and K is `xor_term`. The next state is (J & ~q) | (~K & q), in both D and T modes.
- R7: With `cfg_emu`=2 (S-R), S is the possibly inverted `sum_term` and R is `xor_term`. The next state is ~R & (S | q), so S=R=1 clears the cell.
- R8: `cfg_cell_clk`=0 selects `clk_blk[cfg_bsel]`, and `cfg_cell_clk`=1 selects `clk_cell`. Edges on any unselected clock leave `q` unchanged.
- R9: `apre`=1 forces `q`=1 and `arst`=1 forces `q`=0, both at once and without a clock. When both are high, `arst` wins.
- R10: While `por`=1, `q` equals `cfg_pu_one`, whatever the state of `arst` and `apre`. That value stays after `por` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_blk | input | NUM_BCLK | Shared block clocks |
| clk_cell | input | 1 | Per-cell clock signal |
| cfg_mode | input | 2 | 0 D register, 1 T register, 2 latch (3 behaves as 0) |
| cfg_emu | input | 2 | 0 plain, 1 J-K, 2 S-R (3 behaves as 0) |
| cfg_cell_clk | input | 1 | 1 selects the per-cell clock |
| cfg_bsel | input | SEL_W | Block clock index |
| cfg_clk_inv | input | 1 | Inverts the selected clock |
| cfg_sum_inv | input | 1 | Inverts the sum term |
| cfg_pu_one | input | 1 | Power-up value of q |
| sum_term | input | 1 | Sum-term data input (J or S in emulation) |
| xor_term | input | 1 | Extra term (K or R in emulation) |
| por | input | 1 | Power-up initialisation, active high |
| arst | input | 1 | Asynchronous clear, active high |
| apre | input | 1 | Asynchronous set, active high |
| q | output | 1 | Stored value |

## Verification
The clear and the set can be active together, and the power-up input can overlap both of them. The bench provokes each overlap in every configuration. It raises `apre` alone, then adds `arst`, and it raises both while `por` is high. The result is judged at `q` against the priority order: power-up value, then clear, then set. The sweep covers every mode, emulation, clock source, clock polarity and sum polarity. At each step it also checks that an edge on an unselected clock changes nothing.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  typedef enum logic [1:0] {
    MODE_DREG  = 2'd0,
    MODE_TREG  = 2'd1,
    MODE_LATCH = 2'd2,
    MODE_RSVD  = 2'd3
  } mc_mode_e;

  typedef enum logic [1:0] {
    EMU_NONE = 2'd0,
    EMU_JK   = 2'd1,
    EMU_SR   = 2'd2,
    EMU_RSVD = 2'd3
  } mc_emu_e;
endpackage

// File: rtl/mcell_clk_sel.sv
module mcell_clk_sel #(
  parameter int NUM_BCLK = 4,
  localparam int SEL_W = (NUM_BCLK > 1) ? $clog2(NUM_BCLK) : 1
) (
  input  logic [NUM_BCLK-1:0] clk_blk,
  input  logic                clk_cell,
  input  logic                use_cell,
  input  logic [SEL_W-1:0]    bsel,
  input  logic                inv,
  output logic                ck
);
  logic [NUM_BCLK-1:0] onehot;
  logic                blk_pick;

  // one-hot decode of the block clock index, then an AND-OR mux
  for (genvar i = 0; i < NUM_BCLK; i++) begin : g_dec
    assign onehot[i] = (bsel == SEL_W'(i));
  end

  assign blk_pick = |(onehot & clk_blk);
  assign ck       = (use_cell ? clk_cell : blk_pick) ^ inv;
endmodule

// File: rtl/mcell_alloc.sv
module mcell_alloc
  import mcell_pkg::*;
(
  input  mc_mode_e mode,
  input  mc_emu_e  emu,
  input  logic     sum_inv,
  input  logic     sum_term,
  input  logic     xor_term,
  input  logic     q_fb,
  output logic     nxt,
  output logic     d_lat
);
  logic s_in;
  logic v_xor;

  always_comb begin
    s_in  = sum_term ^ sum_inv;
    v_xor = s_in ^ xor_term;
    d_lat = v_xor;
    case (emu)
      EMU_JK:  nxt = (s_in & ~q_fb) | (~xor_term & q_fb);
      EMU_SR:  nxt = ~xor_term & (s_in | q_fb);
      default: nxt = (mode == MODE_TREG) ? (q_fb ^ v_xor) : v_xor;
    endcase

    if ((emu == EMU_SR) && s_in && xor_term)
      AST_SR_BOTH_CLEARS: assert (nxt == 1'b0) else $error("S=R=1 not clearing"); // R7
    if ((emu == EMU_JK) && s_in && xor_term)
      AST_JK_TOGGLES: assert (nxt != q_fb) else $error("J=K=1 not toggling"); // R6
    if (((emu == EMU_NONE) || (emu == EMU_RSVD)) && (mode == MODE_TREG) && !v_xor)
      AST_T_ZERO_HOLDS: assert (nxt == q_fb) else $error("T=0 changes state"); // R2
  end
endmodule

// File: rtl/mcell_store.sv
module mcell_store
  import mcell_pkg::*;
(
  input  logic     ck,
  input  mc_mode_e mode,
  input  logic     nxt,
  input  logic     d_lat,
  input  logic     por,
  input  logic     pu_one,
  input  logic     arst,
  input  logic     apre,
  output logic     q_edge,
  output logic     q
);
  logic clr;
  logic set;
  logic ovr;
  logic q_l;
  logic ovr_q;

  // priority: power-up value, then clear, then set
  assign clr = por ? ~pu_one : arst;
  assign set = por ? pu_one  : (apre & ~arst);
  assign ovr = clr | set;

  always_ff @(posedge ck or posedge clr or posedge set) begin
    if (clr)      q_edge <= 1'b0;
    else if (set) q_edge <= 1'b1;
    else          q_edge <= nxt;
  end

  always_latch begin
    if (clr)      q_l <= 1'b0;
    else if (set) q_l <= 1'b1;
    else if (ck)  q_l <= d_lat;
  end

  assign q = (mode == MODE_LATCH) ? q_l : q_edge;

  // marks an override seen since the previous active edge (checker use)
  always_ff @(posedge ck or posedge ovr) begin
    if (ovr) ovr_q <= 1'b1;
    else     ovr_q <= 1'b0;
  end

  AST_EDGE_CAPTURE: assert property (@(posedge ck) disable iff (ovr)
    !ovr_q |-> (q_edge == $past(nxt))) else $error("edge capture mismatch"); // R1
  AST_LATCH_FOLLOW: assert property (@(negedge ck) disable iff (ovr)
    (mode == MODE_LATCH) |-> (q == d_lat)) else $error("latch not transparent"); // R3
  AST_CLEAR_WINS: assert property (@(posedge ck) disable iff (por)
    arst |-> (q == 1'b0)) else $error("clear not dominant"); // R9
endmodule

// File: rtl/mcell_reg.sv
module mcell_reg
  import mcell_pkg::*;
#(
  parameter int NUM_BCLK = 4,
  localparam int SEL_W = (NUM_BCLK > 1) ? $clog2(NUM_BCLK) : 1
) (
  input  logic [NUM_BCLK-1:0] clk_blk,
  input  logic                clk_cell,
  input  logic [1:0]          cfg_mode,
  input  logic [1:0]          cfg_emu,
  input  logic                cfg_cell_clk,
  input  logic [SEL_W-1:0]    cfg_bsel,
  input  logic                cfg_clk_inv,
  input  logic                cfg_sum_inv,
  input  logic                cfg_pu_one,
  input  logic                sum_term,
  input  logic                xor_term,
  input  logic                por,
  input  logic                arst,
  input  logic                apre,
  output logic                q
);
  mc_mode_e mode;
  mc_emu_e  emu;
  logic     ck;
  logic     nxt;
  logic     d_lat;
  logic     q_edge;

  assign mode = mc_mode_e'(cfg_mode);
  assign emu  = mc_emu_e'(cfg_emu);

  mcell_clk_sel #(.NUM_BCLK(NUM_BCLK)) u_clk (
    .clk_blk  (clk_blk),
    .clk_cell (clk_cell),
    .use_cell (cfg_cell_clk),
    .bsel     (cfg_bsel),
    .inv      (cfg_clk_inv),
    .ck       (ck)
  );

  mcell_alloc u_alloc (
    .mode     (mode),
    .emu      (emu),
    .sum_inv  (cfg_sum_inv),
    .sum_term (sum_term),
    .xor_term (xor_term),
    .q_fb     (q_edge),
    .nxt      (nxt),
    .d_lat    (d_lat)
  );

  mcell_store u_store (
    .ck     (ck),
    .mode   (mode),
    .nxt    (nxt),
    .d_lat  (d_lat),
    .por    (por),
    .pu_one (cfg_pu_one),
    .arst   (arst),
    .apre   (apre),
    .q_edge (q_edge),
    .q      (q)
  );
endmodule

// File: tb/mcell_reg_bench.sv
`timescale 1ns/1ps
module mcell_reg_bench;
  logic       clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0] src_lv;
  logic [1:0] cfg_mode, cfg_emu, cfg_bsel;
  logic       cfg_cell_clk, cfg_clk_inv, cfg_sum_inv, cfg_pu_one;
  logic       sum_term, xor_term, por, arst, apre, q;
  int n_cmp = 0;
  int n_bad = 0;

  mcell_reg #(.NUM_BCLK(4)) u_mcell_reg (
    .clk_blk(src_lv[3:0]), .clk_cell(src_lv[4]),
    .cfg_mode(cfg_mode), .cfg_emu(cfg_emu), .cfg_cell_clk(cfg_cell_clk),
    .cfg_bsel(cfg_bsel), .cfg_clk_inv(cfg_clk_inv), .cfg_sum_inv(cfg_sum_inv),
    .cfg_pu_one(cfg_pu_one), .sum_term(sum_term), .xor_term(xor_term),
    .por(por), .arst(arst), .apre(apre), .q(q)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%0b expected %0b", tag, act, exp);
    end
  endtask

  // next state from the requirement formulas (R1, R2, R5, R6, R7)
  function automatic logic next_q(int md, int em, logic inv, logic sm, logic xr, logic qo);
    logic s = sm ^ inv;
    if (em == 1) return (s & ~qo) | (~xr & qo);
    if (em == 2) return ~xr & (s | qo);
    if (md == 1) return qo ^ (s ^ xr);
    return s ^ xr;
  endfunction

  function automatic string edge_tag(int md, int em, logic inv);
    if (em == 1) return "R6 J-K edge";
    if (em == 2) return "R7 S-R edge";
    if (inv)     return "R5 inverted sum";
    if (md == 1) return "R2 T edge";
    return "R1 D edge";
  endfunction

  task automatic run_combo(int md, int em, int sidx, logic pol, logic inv, logic pu);
    logic e, d;
    int oth = (sidx + 1) % 5;
    @(negedge clk);
    por = 1'b1; arst = 1'b0; apre = 1'b0;
    cfg_mode = 2'(md); cfg_emu = 2'(em);
    cfg_cell_clk = (sidx == 4);
    cfg_bsel = (sidx == 4) ? 2'd2 : 2'(sidx);
    cfg_clk_inv = pol; cfg_sum_inv = inv; cfg_pu_one = pu;
    src_lv = {5{pol}};
    @(negedge clk); chk("R10 power-up level", q, pu);
    arst = 1'b1; apre = 1'b1;
    @(negedge clk); chk("R10 power-up over clear/set", q, pu);
    arst = 1'b0; apre = 1'b0; por = 1'b0;
    @(negedge clk); chk("R10 value after release", q, pu);
    e = pu;
    for (int k = 0; k < 8; k++) begin
      logic [1:0] pat = 2'(k * 3 + md + em);
      sum_term = pat[0]; xor_term = pat[1];
      @(negedge clk); chk(md == 2 ? "R3 closed holds" : "R1 hold before edge", q, e);
      if (md != 2) begin
        logic en = next_q(md, em, inv, pat[0], pat[1], e);
        src_lv[sidx] = ~pol;
        @(negedge clk); chk(edge_tag(md, em, inv), q, en);
        e = en;
        src_lv[sidx] = pol;
        @(negedge clk); chk("R4 inactive edge holds", q, e);
      end else begin
        d = pat[0] ^ inv ^ pat[1];
        src_lv[sidx] = ~pol;
        @(negedge clk); chk("R3 open follows (R4 level)", q, d);
        sum_term = ~pat[0];
        @(negedge clk); chk("R3 follows change while open", q, ~d);
        e = ~d;
        src_lv[sidx] = pol;
        @(negedge clk);
        sum_term = pat[0];
        @(negedge clk); chk("R3 holds after close", q, e);
      end
      if (k % 2 == 0) begin
        src_lv[oth] = ~src_lv[oth];
        @(negedge clk); chk("R8 unselected clock edge", q, e);
        src_lv[oth] = ~src_lv[oth];
        @(negedge clk); chk("R8 unselected clock return", q, e);
      end
    end
    apre = 1'b1;
    @(negedge clk); chk("R9 set forces one", q, 1'b1);
    arst = 1'b1;
    @(negedge clk); chk("R9 clear beats set", q, 1'b0);
    apre = 1'b0; arst = 1'b0;
    @(negedge clk); chk("R9 state after release", q, 1'b0);
  endtask

  initial begin
    src_lv = '0; cfg_mode = '0; cfg_emu = '0; cfg_bsel = '0;
    cfg_cell_clk = 0; cfg_clk_inv = 0; cfg_sum_inv = 0; cfg_pu_one = 0;
    sum_term = 0; xor_term = 0; por = 0; arst = 0; apre = 0;
    @(negedge clk); por = 1'b1;
    @(negedge clk); chk("R10 reset state", q, 1'b0);
    for (int md = 0; md < 3; md++)
      for (int em = 0; em < 3; em++)
        for (int sidx = 0; sidx < 5; sidx++)
          for (int pol = 0; pol < 2; pol++)
            for (int inv = 0; inv < 2; inv++)
              run_combo(md, em, sidx, 1'(pol), 1'(inv), 1'((md + em + sidx + pol) % 2));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule